// File: doc/BRIEF.md
# Multiply Pipeline Register-Access Interlock

This block guards the shared register file of a three-stage multiply coprocessor. Each cycle it sees whether a command is being issued, and of what kind. It also sees whether a register-file access is requested, in which direction, and against which register class. While a multiply command that is still in flight would make the access unsafe, the block raises `stall`. It raises `acc_grant` in the first cycle the access can proceed.

The four multiply kinds are tracked. Each one sets a valid bit that walks through the stages, one stage per clock. A write to the pixel-input class is never held, because only the first stage reads that class. A write to the coefficient, output or configuration class is held while a command sits in stage 2. A read is held while any command sits in stage 2 or stage 3. When several commands overlap, each is tracked on its own, so the stall lasts as long as the latest conflict.

Top module: `hzi_interlock`

## Requirements
- R1: `cmd_kind` values 0 to 3 (vector multiply, multiply-accumulate, scaled multiply, scaled multiply-accumulate) occupy the pipeline when `cmd_issue` is 1. Kinds 4 to 7 occupy nothing and never cause a stall.
- R2: A read (`acc_write`=0) requested in the cycle right after a multiply issue is stalled for 2 cycles and granted in the third cycle after the issue. A request in the same cycle as an issue is not stalled by that command.
- R3: A write to class 0 (pixel input) is never stalled.
- R4: A write to class 1 (coefficient), 2 (output) or 3 (configuration) requested in the cycle right after a multiply issue is stalled for exactly 1 cycle.
- R5: Each free cycle between issue and request shortens the stall by one. A read two cycles after issue stalls 1 cycle, and a read three or more cycles after stalls none. A class 1 to 3 write two or more cycles after issue stalls none.
- R6: Overlapping multiply commands are tracked independently. A request is stalled while any in-flight command conflicts with it.
- R7: `acc_grant` is 1 exactly when `acc_req` is 1 and `stall` is 0. `stall` is 0 without a request, and `stall` and `acc_grant` are never 1 together.
- R8: A synchronous active-low reset empties every stage. After reset no earlier command causes a stall.
- R9: A pending request keeps `acc_req`, `acc_write` and `acc_cls` unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_issue | input | 1 | A command enters stage 1 this cycle |
| cmd_kind | input | 3 | Command kind; 0 to 3 are multiplies |
| acc_req | input | 1 | Register-file access requested |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cls | input | 2 | Target class: 0 pixel input, 1 coefficient, 2 output, 3 configuration |
| stall | output | 1 | Requested access must wait |
| acc_grant | output | 1 | Requested access proceeds this cycle |

## Verification
The bench places reads and class 1 to 3 writes at zero, one, two and three cycles after a multiply issue. A design with an off-by-one window would grant one cycle early or late. It issues non-multiply kinds directly before reads, which would catch a design that stalls on every command. It issues back-to-back multiplies ahead of a read, which would catch a design that drops the older command and grants too soon. Two further cases are a pixel write right behind a multiply and a reset between issue and read; a design that stalls in either case is caught.

// File: rtl/hzi_pkg.sv
// Shared definitions for the multiply-pipeline interlock.
// Assumes: kinds below MUL_KINDS are multiplies; class encoding is fixed.
package hzi_pkg;

    localparam int MUL_KINDS = 4;

    typedef enum logic [1:0] {
        CLS_PIXEL = 2'd0,
        CLS_COEF  = 2'd1,
        CLS_OUT   = 2'd2,
        CLS_CFG   = 2'd3
    } reg_cls_e;

    // Last pipeline stage (1-based) that uses a register class.
    function automatic int last_use_stage(input reg_cls_e c, input int n_stages);
        return (c == CLS_PIXEL) ? 1 : n_stages;
    endfunction

endpackage

// File: rtl/hzi_stage_track.sv
// Occupancy tracker: a valid bit per pipeline stage behind stage 1.
// Stage 1 is the issue cycle itself; bit s of occ is stage s+1.
// Assumes: the pipeline never freezes, so bits move every clock.
module hzi_stage_track #(
    parameter int NUM_STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_mul,
    output logic [NUM_STAGES-1:1]   occ
);

    logic [NUM_STAGES-1:0] chain;

    assign chain[0] = issue_mul;

    for (genvar s = 1; s < NUM_STAGES; s++) begin : g_stage
        // Advance one multiply command by one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign occ = chain[NUM_STAGES-1:1];

endmodule

// File: rtl/hzi_hazard_eval.sv
// Hazard evaluator: decides from stage occupancy whether the requested
// access conflicts with an in-flight command.
// Assumes: a write lands at the end of its cycle, so it conflicts with
// commands in stages 2 .. (last use stage - 1); a read conflicts with any
// command in stages 2 .. NUM_STAGES whose result is not yet written.
module hzi_hazard_eval
    import hzi_pkg::*;
#(
    parameter int NUM_STAGES = 3
) (
    input  logic [NUM_STAGES-1:1] occ,
    input  logic                  acc_write,
    input  reg_cls_e              acc_cls,
    output logic                  hazard
);

    localparam int LAST_PIX = 1;
    localparam int LAST_SHR = NUM_STAGES;

    logic [NUM_STAGES-1:1] rd_hit;
    logic [NUM_STAGES-1:1] wr_pix_hit;
    logic [NUM_STAGES-1:1] wr_shr_hit;

    for (genvar s = 1; s < NUM_STAGES; s++) begin : g_win
        // Stage index s is pipeline stage s+1.
        assign rd_hit[s]     = occ[s];
        assign wr_pix_hit[s] = ((s + 1) <= (LAST_PIX - 1)) ? occ[s] : 1'b0;
        assign wr_shr_hit[s] = ((s + 1) <= (LAST_SHR - 1)) ? occ[s] : 1'b0;
    end

    // Select the conflict window for the requested direction and class.
    always_comb begin
        if (!acc_write)               hazard = |rd_hit;
        else if (acc_cls == CLS_PIXEL) hazard = |wr_pix_hit;
        else                          hazard = |wr_shr_hit;
    end

endmodule

// File: rtl/hzi_interlock.sv
// Top of the interlock: classifies issued commands, tracks them through
// the stages and turns conflicts into stall / grant.
// Assumes: requester holds a pending access stable until granted.
module hzi_interlock
    import hzi_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    parameter int KIND_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_issue,
    input  logic [KIND_W-1:0] cmd_kind,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic [1:0]        acc_cls,
    output logic              stall,
    output logic              acc_grant
);

    logic                  issue_mul;
    logic [NUM_STAGES-1:1] occ;
    logic                  hazard;
    reg_cls_e              cls_t;

    // Only multiply kinds occupy the pipeline.
    assign issue_mul = cmd_issue && (int'(cmd_kind) < MUL_KINDS);
    assign cls_t     = reg_cls_e'(acc_cls);

    hzi_stage_track #(.NUM_STAGES(NUM_STAGES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_mul (issue_mul),
        .occ       (occ)
    );

    hzi_hazard_eval #(.NUM_STAGES(NUM_STAGES)) u_eval (
        .occ       (occ),
        .acc_write (acc_write),
        .acc_cls   (cls_t),
        .hazard    (hazard)
    );

    // Stall only a pending access; grant it once nothing conflicts.
    always_comb begin
        stall     = acc_req && hazard;
        acc_grant = acc_req && !hazard;
    end

    // R3: pixel-input writes pass regardless of occupancy.
    p_pixel_write_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_write && acc_cls == 2'd0) |-> !stall);

    // R2: a read right after a multiply issue is held.
    p_read_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && issue_mul) && acc_req && !acc_write) |-> stall);

    // R5: a read two cycles after a multiply issue is still held.
    p_read_second_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n && issue_mul, 2) && acc_req && !acc_write) |-> stall);

    // R4: shared-class write right after a multiply issue is held.
    p_shared_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && issue_mul) && acc_req && acc_write && acc_cls != 2'd0) |-> stall);

    // R7: stall and grant are exclusive and need a request.
    p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall, acc_grant}) && ((stall || acc_grant) == acc_req));

    // R8: the cycle after reset carries no stall.
    p_reset_clear_r8: assert property (@(posedge clk)
        $past(!rst_n) |-> !stall);

    // R9: a held request keeps its attributes.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && acc_req && !acc_grant) |->
            (acc_req && $stable(acc_write) && $stable(acc_cls)));

endmodule

// File: tb/sim_hzi_interlock.sv
module sim_hzi_interlock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_issue = 1'b0;
    logic [2:0] cmd_kind = 3'd0;
    logic       acc_req = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_cls = 2'd0;
    logic       stall;
    logic       acc_grant;

    int total = 0;
    int bad = 0;
    bit h1 = 0, h2 = 0;   // multiply issued one / two cycles ago
    bit done = 0;

    always #10 clk = ~clk;

    hzi_interlock u0 (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_kind(cmd_kind),
        .acc_req(acc_req), .acc_write(acc_write), .acc_cls(acc_cls),
        .stall(stall), .acc_grant(acc_grant)
    );

    function automatic bit exp_stall_f(bit req, bit wr, logic [1:0] cls, bit a1, bit a2);
        if (!req) return 0;
        if (!wr) return a1 | a2;
        if (cls == 2'd0) return 0;
        return a1;
    endfunction

    function automatic string tag_of(bit req, bit wr, logic [1:0] cls);
        if (!req) return "R7";
        if (wr && cls == 2'd0) return "R3";
        if (wr) return "R4";
        return "R2";
    endfunction

    // One cycle: drive at negedge, check combinational outputs, advance model.
    task automatic cyc(bit rs, bit iss, logic [2:0] k, bit req, bit wr,
                       logic [1:0] cls, string tag);
        bit es, eg;
        @(negedge clk);
        rst_n = rs; cmd_issue = iss; cmd_kind = k;
        acc_req = req; acc_write = wr; acc_cls = cls;
        #2;
        if (rs && (h1 !== 1'b0 || 1)) begin
            es = exp_stall_f(req, wr, cls, h1, h2);
            eg = req && !es;
            total++;
            if (stall !== es || acc_grant !== eg) begin
                bad++;
                $display("FAIL %s: stall=%b grant=%b expected stall=%b grant=%b",
                         tag, stall, acc_grant, es, eg);
            end
        end
        if (!rs) begin h1 = 0; h2 = 0; end
        else begin h2 = h1; h1 = iss && (k < 3'd4); end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, "R7");
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit pend = 0, pw = 0;
        logic [1:0] pc = 0;
        void'($urandom(32'h5eed));
        cyc(0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 0, "R8");
        // R8: reset state, no stall with a read request
        cyc(1, 0, 0, 1, 0, 1, "R8");
        idle(3);
        // R2: read right after multiply: two stalls then grant
        cyc(1, 1, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 1, 0, 2, "R2");
        cyc(1, 0, 0, 1, 0, 2, "R2");
        cyc(1, 0, 0, 1, 0, 2, "R2");
        // R2: same-cycle issue and read: not stalled
        idle(3);
        cyc(1, 1, 1, 1, 0, 1, "R2");
        idle(3);
        // R4: shared-class writes, one stall each
        for (int c = 1; c < 4; c++) begin
            cyc(1, 1, 2, 0, 0, 0, "R4");
            cyc(1, 0, 0, 1, 1, 2'(c), "R4");
            cyc(1, 0, 0, 1, 1, 2'(c), "R4");
            idle(3);
        end
        // R3: pixel write right after multiply
        cyc(1, 1, 3, 0, 0, 0, "R3");
        cyc(1, 0, 0, 1, 1, 0, "R3");
        idle(3);
        // R5: read after one gap cycle, after two; write after one
        cyc(1, 1, 0, 0, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, 0, "R5");
        cyc(1, 0, 0, 1, 0, 3, "R5");
        cyc(1, 0, 0, 1, 0, 3, "R5");
        idle(3);
        cyc(1, 1, 0, 0, 0, 0, "R5");
        idle(2);
        cyc(1, 0, 0, 1, 0, 0, "R5");
        idle(3);
        cyc(1, 1, 0, 0, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, 0, "R5");
        cyc(1, 0, 0, 1, 1, 3, "R5");
        idle(3);
        // R1: non-multiply kinds never stall
        for (int k = 4; k < 8; k++) begin
            cyc(1, 1, 3'(k), 0, 0, 0, "R1");
            cyc(1, 0, 0, 1, 0, 1, "R1");
        end
        idle(2);
        // R6: back-to-back multiplies extend the read stall
        cyc(1, 1, 0, 0, 0, 0, "R6");
        cyc(1, 1, 1, 1, 0, 2, "R6");
        cyc(1, 1, 2, 1, 0, 2, "R6");
        cyc(1, 0, 0, 1, 0, 2, "R6");
        cyc(1, 0, 0, 1, 0, 2, "R6");
        cyc(1, 0, 0, 1, 0, 2, "R6");
        idle(3);
        // R8: reset between issue and read clears occupancy
        cyc(1, 1, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, "R8");
        cyc(1, 0, 0, 1, 0, 1, "R8");
        idle(3);
        // Random mix; R9: pending request held until granted
        for (int i = 0; i < 4000; i++) begin
            bit iss = ($urandom % 3) == 0;
            logic [2:0] k = 3'($urandom % 8);
            if (!pend && ($urandom % 2)) begin
                pend = 1; pw = 1'($urandom % 2); pc = 2'($urandom % 4);
            end
            cyc(1, iss, k, pend, pw, pc, pend ? tag_of(1, pw, pc) : "R7");
            if (pend && acc_grant) pend = 0;
        end
        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule